// File: doc/BRIEF.md
# Keyed Write Guard for a Protected Control Register

This block keeps one 8-bit control register safe from stray stores. It watches a plain peripheral store bus (valid strobe, address, 8-bit data). The guarded register only changes after a complete unlock ritual. First comes a key store of 0xA5 to a command address. Then three stores to the guarded address follow in order: the new value, its bitwise complement, and the new value again. Any slip in that ritual aborts the unlock and raises a sticky protection-error flag.

The same block holds a small error status byte with three sticky flags. The first records unlock violations. The second records verify failures reported by the flash engine, which signals erase-verify and write-verify failures on separate inputs. The third records attempts to operate on the protected area, or to program a 0 bit back to 1. Software clears a flag by storing a 0 to its bit. Storing a 1 leaves the bit alone. The flash engine itself lies outside this block and only feeds its event inputs.

Top module: `prot_unlock_guard`

## Requirements
- R1: After reset, `prot_o` is 0x00 and `status_o` is 0x00.
- R2: The sequence is: a store of 0xA5 to 0xFFA0, then V to 0xFFA2, then ~V to 0xFFA2, then V to 0xFFA2. It loads V into `prot_o` on the clock edge of the last store and not earlier.
- R3: While no sequence is running, a store to 0xFFA0 with data other than 0xA5 sets status bit 0.
- R4: After the key, if the next store goes to an address other than 0xFFA2, status bit 0 is set and `prot_o` is unchanged.
- R5: If the second guarded store has a wrong address, or data other than the complement of the first value, status bit 0 is set and `prot_o` is unchanged.
- R6: If the third store differs from the first value, or goes to another address, status bit 0 is set and `prot_o` is unchanged.
- R7: After a violation the sequencer is idle. Stores of V, ~V, V without a new key do not change `prot_o`.
- R8: While idle, a store to 0xFFA2 does not change `prot_o` and raises no flag.
- R9: A store to status address 0xFFA1 clears each of bits 0..2 whose data bit is 0 and leaves bits whose data bit is 1. Bits 7..3 always read 0.
- R10: A hardware set of a flag in the same cycle as a software clear of that flag leaves the flag set.
- R11: A pulse on `erase_vfy_fail` or on `write_vfy_fail` sets status bit 1.
- R12: Status bit 2 is set by `cmd_exec` when `cmd_addr_hi` is at or below `area_limit`, or by `prog_zero_to_one`. A command above the limit does not set it.
- R13: Cycles with `st_valid` low between the steps of the sequence do not abort it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store strobe, one store per cycle while high |
| st_addr | input | 16 | Store address |
| st_data | input | 8 | Store data |
| erase_vfy_fail | input | 1 | Erase-verify failure pulse from the flash engine |
| write_vfy_fail | input | 1 | Write-verify failure pulse from the flash engine |
| cmd_exec | input | 1 | Flash command executes this cycle |
| cmd_addr_hi | input | 8 | Upper address byte of the executing command |
| area_limit | input | 8 | Highest upper address byte inside the protected area |
| prog_zero_to_one | input | 1 | Program attempt would turn a 0 bit into 1 |
| prot_o | output | 8 | Guarded register value |
| status_o | output | 8 | Status byte: bit0 protection error, bit1 verify error, bit2 area/program error |

## Verification
A sequencer stuck in the wrong step shows up at the ports on the very next store. An early or late commit moves `prot_o` one store off the expected edge. A lost step raises bit 0 where no error is expected, or fails to load the value. A flag bank with a wrong clear mask or wrong priority shows in `status_o` on the cycle after the status store. The tests therefore sample both outputs after every single store, not only at the end of a scenario.

// File: rtl/prot_unlock_pkg.sv
package prot_unlock_pkg;
  localparam int AW      = 16;
  localparam int DW      = 8;
  localparam int NFLAGS  = 3;
  localparam int FLG_PE  = 0;
  localparam int FLG_VFY = 1;
  localparam int FLG_WEP = 2;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_VAL  = 2'd1,
    S_INV  = 2'd2,
    S_CONF = 2'd3
  } seq_state_t;
endpackage

// File: rtl/unlock_fsm.sv
module unlock_fsm
  import prot_unlock_pkg::*;
#(
  parameter logic [AW-1:0] CMD_ADDR  = 16'hFFA0,
  parameter logic [AW-1:0] PROT_ADDR = 16'hFFA2,
  parameter logic [DW-1:0] KEY       = 8'hA5,
  parameter logic [DW-1:0] PROT_RST  = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          pe_set,
  output logic [DW-1:0] prot_q
);
  seq_state_t    state_q, state_d;
  logic [DW-1:0] val_q;
  logic          cap_val, commit;
  logic          hit_cmd, hit_prot;

  assign hit_cmd  = (st_addr == CMD_ADDR);
  assign hit_prot = (st_addr == PROT_ADDR);

  always_comb begin
    state_d = state_q;
    pe_set  = 1'b0;
    cap_val = 1'b0;
    commit  = 1'b0;
    if (st_valid) begin
      unique case (state_q)
        S_IDLE: begin
          if (hit_cmd) begin
            if (st_data == KEY) state_d = S_VAL;
            else                pe_set  = 1'b1;
          end
        end
        S_VAL: begin
          if (hit_prot) begin
            cap_val = 1'b1;
            state_d = S_INV;
          end else begin
            pe_set  = 1'b1;
            state_d = S_IDLE;
          end
        end
        S_INV: begin
          if (hit_prot && st_data == ~val_q) state_d = S_CONF;
          else begin
            pe_set  = 1'b1;
            state_d = S_IDLE;
          end
        end
        S_CONF: begin
          state_d = S_IDLE;
          if (hit_prot && st_data == val_q) commit = 1'b1;
          else                              pe_set = 1'b1;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      val_q   <= '0;
      prot_q  <= PROT_RST;
    end else begin
      state_q <= state_d;
      if (cap_val) val_q  <= st_data;
      if (commit)  prot_q <= val_q;
    end
  end

  // R2
  commit_only_after_conf_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_q != $past(prot_q)) |-> $past(state_q == S_CONF && st_valid));

  // R7
  idle_after_violation_chk: assert property (@(posedge clk) disable iff (rst)
    pe_set |=> (state_q == S_IDLE));
endmodule

// File: rtl/area_guard.sv
module area_guard #(
  parameter int HW = 8
) (
  input  logic          cmd_exec,
  input  logic [HW-1:0] cmd_addr_hi,
  input  logic [HW-1:0] area_limit,
  input  logic          prog_zero_to_one,
  output logic          wep_set
);
  logic in_area;
  assign in_area = (cmd_addr_hi <= area_limit);
  assign wep_set = (cmd_exec && in_area) || prog_zero_to_one;
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         clr_we,
  input  logic [N-1:0] clr_data,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                          flag_q[i] <= 1'b0;
      else if (set_vec[i])              flag_q[i] <= 1'b1;
      else if (clr_we && !clr_data[i])  flag_q[i] <= 1'b0;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> flag_q[i]);

    // R9
    clear_needs_zero_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(flag_q[i]) |-> $past(clr_we && !clr_data[i]));
  end
endmodule

// File: rtl/prot_unlock_guard.sv
module prot_unlock_guard
  import prot_unlock_pkg::*;
#(
  parameter logic [AW-1:0] CMD_ADDR  = 16'hFFA0,
  parameter logic [AW-1:0] STAT_ADDR = 16'hFFA1,
  parameter logic [AW-1:0] PROT_ADDR = 16'hFFA2,
  parameter logic [DW-1:0] KEY       = 8'hA5,
  parameter logic [DW-1:0] PROT_RST  = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  input  logic [15:0]   st_addr,
  input  logic [7:0]    st_data,
  input  logic          erase_vfy_fail,
  input  logic          write_vfy_fail,
  input  logic          cmd_exec,
  input  logic [7:0]    cmd_addr_hi,
  input  logic [7:0]    area_limit,
  input  logic          prog_zero_to_one,
  output logic [7:0]    prot_o,
  output logic [7:0]    status_o
);
  localparam int PAD = DW - NFLAGS;

  logic              pe_set, wep_set, vfy_set;
  logic [NFLAGS-1:0] set_vec, flags;
  logic              clr_we;

  unlock_fsm #(
    .CMD_ADDR (CMD_ADDR),
    .PROT_ADDR(PROT_ADDR),
    .KEY      (KEY),
    .PROT_RST (PROT_RST)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .st_valid(st_valid),
    .st_addr (st_addr),
    .st_data (st_data),
    .pe_set  (pe_set),
    .prot_q  (prot_o)
  );

  area_guard #(.HW(8)) u_area (
    .cmd_exec        (cmd_exec),
    .cmd_addr_hi     (cmd_addr_hi),
    .area_limit      (area_limit),
    .prog_zero_to_one(prog_zero_to_one),
    .wep_set         (wep_set)
  );

  assign vfy_set          = erase_vfy_fail | write_vfy_fail;
  assign set_vec[FLG_PE]  = pe_set;
  assign set_vec[FLG_VFY] = vfy_set;
  assign set_vec[FLG_WEP] = wep_set;
  assign clr_we           = st_valid && (st_addr == STAT_ADDR);

  flag_bank #(.N(NFLAGS)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_we  (clr_we),
    .clr_data(st_data[NFLAGS-1:0]),
    .flag_q  (flags)
  );

  assign status_o = {{PAD{1'b0}}, flags};

  // R11
  vfy_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (erase_vfy_fail || write_vfy_fail) |=> status_o[FLG_VFY]);

  // R12
  area_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_exec && (cmd_addr_hi <= area_limit)) |=> status_o[FLG_WEP]);
endmodule

// File: tb/sim_prot_unlock_guard.sv
`timescale 1ns/1ps
module sim_prot_unlock_guard;
  localparam logic [15:0] A_CMD  = 16'hFFA0;
  localparam logic [15:0] A_STAT = 16'hFFA1;
  localparam logic [15:0] A_PROT = 16'hFFA2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 1'b0;
  logic [15:0] st_addr = '0;
  logic [7:0]  st_data = '0;
  logic        erase_vfy_fail = 1'b0, write_vfy_fail = 1'b0;
  logic        cmd_exec = 1'b0, prog_zero_to_one = 1'b0;
  logic [7:0]  cmd_addr_hi = '0, area_limit = 8'h80;
  logic [7:0]  prot_o, status_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  prot_unlock_guard u0 (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .erase_vfy_fail(erase_vfy_fail), .write_vfy_fail(write_vfy_fail),
    .cmd_exec(cmd_exec), .cmd_addr_hi(cmd_addr_hi), .area_limit(area_limit),
    .prog_zero_to_one(prog_zero_to_one), .prot_o(prot_o), .status_o(status_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // one store; returns at the negedge after its clock edge
  task automatic store(input logic [15:0] a, input logic [7:0] d);
    st_valid = 1'b1; st_addr = a; st_data = d;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    store(A_STAT, 8'h00);
  endtask

  task automatic t_reset();
    chk("R1 prot", prot_o, 8'h00);
    chk("R1 status", status_o, 8'h00);
  endtask

  task automatic t_good();
    store(A_CMD, 8'hA5);
    store(A_PROT, 8'h3C);
    store(A_PROT, 8'hC3);
    chk("R2 not before third", prot_o, 8'h00);
    store(A_PROT, 8'h3C);
    chk("R2 loaded", prot_o, 8'h3C);
    chk("R2 no error", status_o, 8'h00);
  endtask

  task automatic t_gaps();
    store(A_CMD, 8'hA5); idle(3);
    store(A_PROT, 8'h5A); idle(2);
    store(A_PROT, 8'hA5); idle(1);
    store(A_PROT, 8'h5A);
    chk("R13 loaded", prot_o, 8'h5A);
    chk("R13 no error", status_o, 8'h00);
  endtask

  task automatic t_bad_key();
    store(A_CMD, 8'h5A);
    chk("R3 flag", status_o, 8'h01);
    clear_all();
    chk("R9 cleared", status_o, 8'h00);
  endtask

  task automatic t_wrong_addr();
    store(A_CMD, 8'hA5);
    store(16'h1234, 8'h00);
    chk("R4 flag", status_o, 8'h01);
    chk("R4 prot kept", prot_o, 8'h5A);
    clear_all();
  endtask

  task automatic t_bad_inv();
    store(A_CMD, 8'hA5);
    store(A_PROT, 8'h11);
    store(A_PROT, 8'hEF);
    chk("R5 flag", status_o, 8'h01);
    store(A_PROT, 8'h11);
    store(A_PROT, 8'hEE);
    store(A_PROT, 8'h11);
    chk("R7 no unkeyed load", prot_o, 8'h5A);
    chk("R7 flag only once", status_o, 8'h01);
    clear_all();
  endtask

  task automatic t_bad_inv_addr();
    store(A_CMD, 8'hA5);
    store(A_PROT, 8'h44);
    store(16'hFFA3, 8'hBB);
    chk("R5 addr flag", status_o, 8'h01);
    chk("R5 prot kept", prot_o, 8'h5A);
    clear_all();
  endtask

  task automatic t_bad_conf();
    store(A_CMD, 8'hA5);
    store(A_PROT, 8'h22);
    store(A_PROT, 8'hDD);
    store(A_PROT, 8'h23);
    chk("R6 flag", status_o, 8'h01);
    chk("R6 prot kept", prot_o, 8'h5A);
    clear_all();
  endtask

  task automatic t_idle_prot();
    store(A_PROT, 8'h77);
    chk("R8 prot kept", prot_o, 8'h5A);
    chk("R8 no flag", status_o, 8'h00);
  endtask

  task automatic t_vfy_and_mask();
    erase_vfy_fail = 1'b1; @(negedge clk); erase_vfy_fail = 1'b0;
    chk("R11 erase", status_o, 8'h02);
    store(A_CMD, 8'h00);
    chk("R3 with vfy", status_o, 8'h03);
    store(A_STAT, 8'h02);
    chk("R9 write1 keeps", status_o, 8'h02);
    clear_all();
    write_vfy_fail = 1'b1; @(negedge clk); write_vfy_fail = 1'b0;
    chk("R11 write", status_o, 8'h02);
    clear_all();
    store(A_STAT, 8'hFF);
    chk("R9 upper zero", status_o, 8'h00);
  endtask

  task automatic t_area();
    area_limit = 8'h80;
    cmd_addr_hi = 8'h81; cmd_exec = 1'b1; @(negedge clk); cmd_exec = 1'b0;
    chk("R12 above limit", status_o, 8'h00);
    cmd_addr_hi = 8'h80; cmd_exec = 1'b1; @(negedge clk); cmd_exec = 1'b0;
    chk("R12 at limit", status_o, 8'h04);
    clear_all();
    chk("R12 cleared", status_o, 8'h00);
    prog_zero_to_one = 1'b1; @(negedge clk); prog_zero_to_one = 1'b0;
    chk("R12 zero to one", status_o, 8'h04);
    clear_all();
  endtask

  task automatic t_prio();
    erase_vfy_fail = 1'b1;
    store(A_STAT, 8'h00);
    erase_vfy_fail = 1'b0;
    chk("R10 set wins", status_o, 8'h02);
    clear_all();
    chk("R10 later clear", status_o, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    @(negedge clk);
    t_good();
    t_gaps();
    t_bad_key();
    t_wrong_addr();
    t_bad_inv();
    t_bad_inv_addr();
    t_bad_conf();
    t_idle_prot();
    t_vfy_and_mask();
    t_area();
    t_prio();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule